// File: doc/BRIEF.md
# Five-Source Priority Interrupt Controller

This block sits next to a small processor core. It watches five interrupt request inputs and decides, once per instruction, whether the core should be interrupted, and by which source. The core pulses a sample strobe during the next-to-last clock of every instruction. On that clock the controller looks at all five inputs together, applies the per-source masks and the global enable, and picks the winner by a fixed priority. In the following cycle it reports the winner as a valid flag, a one-hot acknowledge and a restart vector address.

The top source is non-maskable. Three restart sources each have their own mask bit and a fixed vector. The lowest source is a general request. For that source the block raises the valid flag but gives a zero vector, so the requesting device has to supply the opcode. When any maskable source is taken, the global enable is cleared. It stays cleared until the core issues an explicit enable command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During and after reset `irq_valid_o` is 0, `irq_ack_o` is 0 and `irq_vec_o` is 0. The global enable starts cleared and all three mask bits start set.
- R2: A decision is made only on a clock edge at which `sample_i` is high. The result appears on the outputs after that edge and lasts exactly one cycle. With `sample_i` low, the outputs next cycle are all zero.
- R3: The priority, highest first, is: non-maskable, restart high, restart mid, restart low, general. `irq_ack_o` is one-hot or zero, with bit 4 = non-maskable, bit 3 = high, bit 2 = mid, bit 1 = low and bit 0 = general. `irq_valid_o` is high exactly when `irq_ack_o` is nonzero.
- R4: The vectors are 16'h0024 for non-maskable, 16'h003C for high, 16'h0034 for mid and 16'h002C for low.
- R5: A taken general request gives `irq_valid_o`=1, `irq_ack_o`=5'b00001 and `irq_vec_o`=0.
- R6: The non-maskable source is taken regardless of the mask bits and the global enable.
- R7: The non-maskable source qualifies at a sample only if `nmi_i` has risen since the previous sample (the rise may be in the sample cycle itself) and `nmi_i` is still high at the sample. Every sample clears the remembered rise. So a line held high is taken once, and a pulse that ends before the sample is dropped.
- R8: `mask_we_i` loads `mask_wdata_i` into the mask. Bit 2 blocks the high source, bit 1 blocks the mid source and bit 0 blocks the low source. A set bit blocks that source.
- R9: The three restart sources and the general request need the global enable. `en_set_i` sets the enable. `en_clr_i` clears it, and so does taking any maskable source. If a clear and a set happen on the same edge, the clear wins.
- R10: A mask write or an enable command on the same edge as a sample does not affect that sample. It only affects later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Sample strobe, next-to-last clock of an instruction |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 3 | New mask value {high, mid, low} |
| en_set_i | input | 1 | Set global enable |
| en_clr_i | input | 1 | Clear global enable |
| nmi_i | input | 1 | Non-maskable request |
| rq_hi_i | input | 1 | Restart request, high level |
| rq_mid_i | input | 1 | Restart request, mid level |
| rq_lo_i | input | 1 | Restart request, low level |
| gen_rq_i | input | 1 | General request, lowest priority |
| irq_valid_o | output | 1 | An interrupt was taken at the last sample |
| irq_vec_o | output | 16 | Restart vector of the taken source, zero for general |
| irq_ack_o | output | 5 | One-hot acknowledge of the taken source |

## Verification
The internal state consists of the global enable, the three mask bits and the remembered non-maskable rise. None of it is visible directly. An error there shows up at the first later sample where that state decides the outcome. A stuck enable shows up as a second maskable acceptance without an enable command in between. A wrong mask bit shows up as the wrong winner. A lost or stale rise shows up as a missing or repeated non-maskable acknowledge. The bench therefore compares all three outputs in the cycle after every edge against a model kept from the requirements. Each deviation is caught one cycle after the sample that exposes it.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_NMI = 16'h0024,
  parameter logic [VW-1:0] VEC_HI  = 16'h003C,
  parameter logic [VW-1:0] VEC_MID = 16'h0034,
  parameter logic [VW-1:0] VEC_LO  = 16'h002C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_i,
  input  logic          mask_we_i,
  input  logic [2:0]    mask_wdata_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          nmi_i,
  input  logic          rq_hi_i,
  input  logic          rq_mid_i,
  input  logic          rq_lo_i,
  input  logic          gen_rq_i,
  output logic          irq_valid_o,
  output logic [VW-1:0] irq_vec_o,
  output logic [4:0]    irq_ack_o
);

  logic          ie_q, nmi_q, nmi_pend_q;
  logic [2:0]    mask_q;
  logic          nmi_rise, nmi_hit, gen_hit;
  logic [2:0]    lvl_hit;
  logic [4:0]    grant;
  logic [VW-1:0] grant_vec;
  logic          take_mask;

  assign nmi_rise  = nmi_i & ~nmi_q;
  assign nmi_hit   = (nmi_pend_q | nmi_rise) & nmi_i;
  assign lvl_hit   = {rq_hi_i, rq_mid_i, rq_lo_i} & ~mask_q & {3{ie_q}};
  assign gen_hit   = gen_rq_i & ie_q;

  always_comb begin
    grant     = '0;
    grant_vec = '0;
    if (nmi_hit)         begin grant = 5'b10000; grant_vec = VEC_NMI; end
    else if (lvl_hit[2]) begin grant = 5'b01000; grant_vec = VEC_HI;  end
    else if (lvl_hit[1]) begin grant = 5'b00100; grant_vec = VEC_MID; end
    else if (lvl_hit[0]) begin grant = 5'b00010; grant_vec = VEC_LO;  end
    else if (gen_hit)    begin grant = 5'b00001; end
  end

  assign take_mask = sample_i & (|grant[3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q        <= 1'b0;
      mask_q      <= 3'b111;
      nmi_q       <= 1'b0;
      nmi_pend_q  <= 1'b0;
      irq_valid_o <= 1'b0;
      irq_vec_o   <= '0;
      irq_ack_o   <= '0;
    end else begin
      nmi_q <= nmi_i;
      if (sample_i)      nmi_pend_q <= 1'b0;
      else if (nmi_rise) nmi_pend_q <= 1'b1;
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (en_clr_i || take_mask) ie_q <= 1'b0;
      else if (en_set_i)         ie_q <= 1'b1;
      irq_valid_o <= sample_i & (|grant);
      irq_ack_o   <= sample_i ? grant : 5'b0;
      irq_vec_o   <= sample_i ? grant_vec : '0;
    end
  end

  a_r2_only_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> $past(sample_i));
  a_r3_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack_o));
  a_r3_valid_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o == (irq_ack_o != 5'b0));
  a_r4_vec_hi: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o[3] |-> irq_vec_o == VEC_HI);
  a_r5_gen_no_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o[0] |-> irq_vec_o == '0);
  a_r7_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o[4] |-> $past(nmi_i));
  a_r8_hi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o[3] |-> !$past(mask_q[2]));
  a_r9_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o[3:0]) |-> !ie_q);

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_i = 0, mask_we_i = 0, en_set_i = 0, en_clr_i = 0;
  logic [2:0] mask_wdata_i = 0;
  logic nmi_i = 0, rq_hi_i = 0, rq_mid_i = 0, rq_lo_i = 0, gen_rq_i = 0;
  logic irq_valid_o;
  logic [15:0] irq_vec_o;
  logic [4:0] irq_ack_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .mask_we_i(mask_we_i),
    .mask_wdata_i(mask_wdata_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .nmi_i(nmi_i), .rq_hi_i(rq_hi_i), .rq_mid_i(rq_mid_i), .rq_lo_i(rq_lo_i),
    .gen_rq_i(gen_rq_i), .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o),
    .irq_ack_o(irq_ack_o));

  // reference model built from the requirements
  bit m_ie, m_prev, m_pend;
  bit [2:0] m_mask;
  bit exp_valid;
  bit [4:0] exp_ack;
  bit [15:0] exp_vec;

  function automatic bit [4:0] pick(bit nmi_ok, bit ie, bit [2:0] msk,
                                    bit hi, bit mid, bit lo, bit gen);
    if (nmi_ok) return 5'b10000;             // R6: no mask, no enable
    if (ie && hi && !msk[2]) return 5'b01000; // R3 order, R8 bit 2
    if (ie && mid && !msk[1]) return 5'b00100;
    if (ie && lo && !msk[0]) return 5'b00010;
    if (ie && gen) return 5'b00001;          // R5
    return 5'b00000;
  endfunction

  function automatic bit [15:0] vec_of(bit [4:0] a);
    case (a)
      5'b10000: return 16'h0024;
      5'b01000: return 16'h003C;
      5'b00100: return 16'h0034;
      5'b00010: return 16'h002C;
      default:  return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_prev = 0; m_pend = 0; m_mask = 3'b111;
      exp_valid = 0; exp_ack = 0; exp_vec = 0;
    end else begin
      bit rise, nmi_ok;
      bit [4:0] g;
      rise = nmi_i && !m_prev;
      nmi_ok = (m_pend || rise) && nmi_i;                  // R7
      g = sample_i ? pick(nmi_ok, m_ie, m_mask, rq_hi_i, rq_mid_i, rq_lo_i, gen_rq_i) : 5'b0; // R2
      exp_ack = g; exp_valid = (g != 0); exp_vec = vec_of(g);
      if (sample_i) m_pend = 0; else if (rise) m_pend = 1;
      if (en_clr_i || (|g[3:0])) m_ie = 0;                 // R9, R10
      else if (en_set_i) m_ie = 1;
      if (mask_we_i) m_mask = mask_wdata_i;
      m_prev = nmi_i;
    end
  end

  task automatic check(string tag);
    n_checks++;
    if (irq_valid_o !== exp_valid || irq_ack_o !== exp_ack || irq_vec_o !== exp_vec) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b ack=%b vec=%h, expected valid=%0b ack=%b vec=%h",
               tag, irq_valid_o, irq_ack_o, irq_vec_o, exp_valid, exp_ack, exp_vec);
    end
  endtask

  function automatic string tag_of(bit [4:0] a);
    case (a)
      5'b10000: return "R6";
      5'b01000: return "R4";
      5'b00100: return "R3";
      5'b00010: return "R8";
      5'b00001: return "R5";
      default:  return "R2";
    endcase
  endfunction

  task automatic step(bit smp, bit nmi, bit hi, bit mid, bit lo, bit gen,
                      bit mwe, bit [2:0] mw, bit es, bit ec, string tag);
    sample_i = smp; nmi_i = nmi; rq_hi_i = hi; rq_mid_i = mid; rq_lo_i = lo;
    gen_rq_i = gen; mask_we_i = mwe; mask_wdata_i = mw; en_set_i = es; en_clr_i = ec;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");
    // R9: enable off and all masked at reset, nothing taken
    step(1,0,1,1,1,1, 0,0,0,0, "R9");
    // R6: non-maskable rise taken despite enable off
    step(0,1,0,0,0,0, 0,0,0,0, "R6");
    step(1,1,0,0,0,0, 0,0,0,0, "R6");
    step(0,1,0,0,0,0, 0,0,0,0, "R4");
    // R7: held high, not taken again
    step(1,1,0,0,0,0, 0,0,0,0, "R7");
    step(0,0,0,0,0,0, 0,0,0,0, "R7");
    // R7: pulse ends before the sample
    step(0,1,0,0,0,0, 0,0,0,0, "R7");
    step(0,0,0,0,0,0, 0,0,0,0, "R7");
    step(1,0,0,0,0,0, 0,0,0,0, "R7");
    // R7: rise in the sample cycle itself
    step(1,1,0,0,0,0, 0,0,0,0, "R7");
    step(0,0,0,0,0,0, 0,0,0,0, "R7");
    // R8 R3: unmask all, enable, everything pending -> high level
    step(0,0,0,0,0,0, 1,3'b000,1,0, "R8");
    step(1,0,1,1,1,1, 0,0,0,0, "R3");
    // R9: enable dropped after acceptance
    step(1,0,0,1,0,0, 0,0,0,0, "R9");
    // R8: mask high only, mid wins
    step(0,0,0,0,0,0, 1,3'b100,1,0, "R8");
    step(1,0,1,1,0,0, 0,0,0,0, "R8");
    // R5: general only
    step(0,0,0,0,0,0, 0,0,1,0, "R5");
    step(1,0,0,0,0,1, 0,0,0,0, "R5");
    // R9: set and clear on the same edge, clear wins
    step(0,0,0,0,0,0, 0,0,1,1, "R9");
    step(1,0,0,0,1,0, 0,0,0,0, "R9");
    // R10: mask write on the sample edge uses old mask
    step(0,0,0,0,0,0, 1,3'b111,1,0, "R10");
    step(1,0,0,0,1,0, 1,3'b000,0,0, "R10");
    step(1,0,0,0,1,0, 0,0,0,0, "R10");
    // R10: enable set on the sample edge does not count for it
    step(1,0,0,0,1,0, 0,0,1,0, "R10");
    step(1,0,0,0,1,0, 0,0,0,0, "R10");
    // R2: requests without a sample
    step(0,0,1,1,1,1, 0,0,1,0, "R2");
    step(0,1,1,1,1,1, 0,0,0,0, "R2");
    // R1: reset again mid-run
    rst_n = 0;
    step(0,0,0,0,0,0, 0,0,0,0, "R1");
    rst_n = 1;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit smp, nmi, es, ec, mwe;
      smp = ($urandom % 4) == 0;
      nmi = (($urandom % 8) == 0) ? !nmi_i : nmi_i;
      mwe = ($urandom % 16) == 0;
      es  = ($urandom % 6) == 0;
      ec  = ($urandom % 20) == 0;
      sample_i = smp; nmi_i = nmi; rq_hi_i = $urandom % 2; rq_mid_i = $urandom % 2;
      rq_lo_i = $urandom % 2; gen_rq_i = $urandom % 2; mask_we_i = mwe;
      mask_wdata_i = 3'($urandom); en_set_i = es; en_clr_i = ec;
      @(posedge clk);
      @(negedge clk);
      check(tag_of(exp_ack));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule